// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller. Its pins are split into banks of sixteen, and every bank owns an identical register window at a fixed stride. Software uses a window to decide whether each pin drives or receives, which data bits a write may touch, whether the receive path is live, and how each pin raises an interrupt.

Each pin can raise an interrupt on a high level, a low level, a rising edge, a falling edge or either edge. Edge events stay latched until software writes a one to the matching clear bit. Level conditions are never latched and simply follow the pin. A per-pin enable gates the latched or live status into a masked view. Every masked bit in every bank feeds one shared interrupt line.

Pin inputs cross into the clock domain through a two-stage synchroniser. The register bus reads back with no wait state: read data is a combinational function of the address.

Top module: `gpio_banked`

## Requirements
- R1: Bank b is decoded at byte address b*0x80, and bit n of its registers belongs to pin 16*b+n. Only the low 16 bits of a register are stored, and bits 31:16 always read 0. Word offsets within a bank: output data 0x00, write mask 0x04, drive select 0x08, level-mode select 0x0C, any-edge select 0x10, polarity 0x14, irq enable 0x18, raw status 0x1C (read only), gated status 0x20 (read only), clear 0x24 (write only), receive enable 0x28.
- R2: After reset, every stored register is zero, `pin_out` and `pin_oe` are zero, and `irq_out` is low.
- R3: `pin_oe` for a pin equals its drive-select bit, where 1 means output. `pin_out` equals the pin's stored output-data bit.
- R4: A data write changes only bits whose write-mask bit is 1. Reading data returns 0 in every bit whose write-mask bit is 0.
- R5: For a pin with write-mask bit 1, a data read returns the stored output bit when drive select is 1. When drive select is 0, it returns the synchronised input if the receive-enable bit is 1, and 0 otherwise.
- R6: With level-mode select 0 and any-edge select 0, polarity 1 latches raw status on a rising input and polarity 0 latches it on a falling input. A latched bit stays set after the pin returns to its old value.
- R7: With level-mode select 0, any-edge select 1 latches on both rising and falling inputs, whatever the polarity bit holds.
- R8: With level-mode select 1, raw status is 1 exactly while the synchronised input equals the polarity bit (1 means active high, 0 means active low). It drops with no clear write.
- R9: Writing 1 to a clear bit resets that pin's latched edge status, and a 0 leaves it unchanged. The clear word reads 0. Writes to the raw and gated status words have no effect.
- R10: When a new qualifying edge arrives in the same cycle as a clear write to that bit, the latched status stays 1.
- R11: Gated status is raw status AND irq enable. `irq_out` is 1 exactly when some gated status bit in any bank is 1.
- R12: A pin whose receive-enable bit is 0 neither sets edge status nor asserts level status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 11 | Byte address (bank index above bit 7, word index in bits 6:2) |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 256 | Raw pin inputs |
| pin_out | output | 256 | Pin output values |
| pin_oe | output | 256 | Pin output enables |
| irq_out | output | 1 | OR of every gated status bit |

## Verification
The hardest case to reach is a clear write that lands in exactly the cycle when the synchroniser presents a fresh edge on the same pin. That cycle sits two register stages behind the pin change. The stimulus first latches an edge on an any-edge pin. It then moves the pin back and waits through both synchroniser stages, so the clear strobe is sampled on the same clock edge that latches the new event. A follow-up clear with no edge confirms the bit then drops.

// File: rtl/gpiob_pkg.sv
package gpiob_pkg;
    localparam int PIN_W       = 16;
    localparam int WIN_LG      = 7;
    localparam int WORD_IDX_W  = 5;

    typedef enum logic [WORD_IDX_W-1:0] {
        REG_DATA  = 5'h00,
        REG_DMASK = 5'h01,
        REG_DIR   = 5'h02,
        REG_SENSE = 5'h03,
        REG_BOTH  = 5'h04,
        REG_POL   = 5'h05,
        REG_IEN   = 5'h06,
        REG_RAW   = 5'h07,
        REG_MSK   = 5'h08,
        REG_CLR   = 5'h09,
        REG_INEN  = 5'h0A
    } reg_sel_e;

    typedef enum logic [2:0] {
        DET_RISE,
        DET_FALL,
        DET_BOTH,
        DET_HIGH,
        DET_LOW
    } det_mode_e;
endpackage

// File: rtl/gpiob_sync.sv
module gpiob_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] s_now,
    output logic [W-1:0] s_prev
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    assign s_now  = stage2_q;
    assign s_prev = prev_q;
endmodule

// File: rtl/gpiob_detect.sv
module gpiob_detect
    import gpiob_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] s_now,
    input  logic [W-1:0] s_prev,
    input  logic [W-1:0] sense,
    input  logic [W-1:0] both,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] inen,
    input  logic [W-1:0] clr,
    output logic [W-1:0] raw
);
    logic [W-1:0] hit;
    logic [W-1:0] edge_set;
    logic [W-1:0] latch_q;

    for (genvar i = 0; i < W; i++) begin : g_pin
        det_mode_e mode;
        logic      rise;
        logic      fall;
        logic      hit_b;

        assign rise = s_now[i] & ~s_prev[i];
        assign fall = ~s_now[i] & s_prev[i];

        always_comb begin
            if (sense[i])     mode = pol[i] ? DET_HIGH : DET_LOW;
            else if (both[i]) mode = DET_BOTH;
            else              mode = pol[i] ? DET_RISE : DET_FALL;
        end

        always_comb begin
            unique case (mode)
                DET_RISE: hit_b = rise;
                DET_FALL: hit_b = fall;
                DET_BOTH: hit_b = rise | fall;
                DET_HIGH: hit_b = s_now[i];
                DET_LOW:  hit_b = ~s_now[i];
                default:  hit_b = 1'b0;
            endcase
        end

        assign hit[i] = hit_b & inen[i];
    end

    assign edge_set = hit & ~sense;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= ((latch_q & ~clr) | edge_set) & ~sense;
    end

    assign raw = (hit & sense) | latch_q;

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((($past(latch_q) & ~latch_q) & ~$past(clr)) & ~$past(sense)) == '0));

    assert_clear_race_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch_q & $past(edge_set)) == $past(edge_set)));
endmodule

// File: rtl/gpiob_bank.sv
module gpiob_bank
    import gpiob_pkg::*;
#(
    parameter int W = PIN_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  logic                  we,
    input  logic [WORD_IDX_W-1:0] word_idx,
    input  logic [W-1:0]          wdata,
    input  logic [W-1:0]          pin_in,
    output logic [W-1:0]          rdata,
    output logic [W-1:0]          pin_out,
    output logic [W-1:0]          pin_oe,
    output logic [W-1:0]          masked
);
    logic [W-1:0] dout_q, dmask_q, dir_q, sense_q, both_q, pol_q, ien_q, inen_q;
    logic [W-1:0] s_now, s_prev, raw, clr_vec, data_view;
    logic         wr_hit;
    reg_sel_e     wsel;

    assign wsel   = reg_sel_e'(word_idx);
    assign wr_hit = sel & we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= '0;
            dmask_q <= '0;
            dir_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            ien_q   <= '0;
            inen_q  <= '0;
        end else if (wr_hit) begin
            unique case (wsel)
                REG_DATA:  dout_q  <= (dout_q & ~dmask_q) | (wdata & dmask_q);
                REG_DMASK: dmask_q <= wdata;
                REG_DIR:   dir_q   <= wdata;
                REG_SENSE: sense_q <= wdata;
                REG_BOTH:  both_q  <= wdata;
                REG_POL:   pol_q   <= wdata;
                REG_IEN:   ien_q   <= wdata;
                REG_INEN:  inen_q  <= wdata;
                default: ;
            endcase
        end
    end

    assign clr_vec = (wr_hit && (wsel == REG_CLR)) ? wdata : '0;

    gpiob_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .s_now    (s_now),
        .s_prev   (s_prev)
    );

    gpiob_detect #(.W(W)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .s_now  (s_now),
        .s_prev (s_prev),
        .sense  (sense_q),
        .both   (both_q),
        .pol    (pol_q),
        .inen   (inen_q),
        .clr    (clr_vec),
        .raw    (raw)
    );

    assign masked    = raw & ien_q;
    assign pin_out   = dout_q;
    assign pin_oe    = dir_q;
    assign data_view = dmask_q & ((dir_q & dout_q) | (~dir_q & inen_q & s_now));

    always_comb begin
        unique case (wsel)
            REG_DATA:  rdata = data_view;
            REG_DMASK: rdata = dmask_q;
            REG_DIR:   rdata = dir_q;
            REG_SENSE: rdata = sense_q;
            REG_BOTH:  rdata = both_q;
            REG_POL:   rdata = pol_q;
            REG_IEN:   rdata = ien_q;
            REG_RAW:   rdata = raw;
            REG_MSK:   rdata = masked;
            REG_INEN:  rdata = inen_q;
            default:   rdata = '0;
        endcase
    end

    assert_mask_protect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (wsel == REG_DATA)) |=> (((dout_q ^ $past(dout_q)) & ~$past(dmask_q)) == '0));

    assert_oe_follows_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (wsel == REG_DIR)) |=> (pin_oe == $past(wdata)));
endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
    import gpiob_pkg::*;
#(
    parameter int NUM_BANKS  = 16,
    parameter int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    parameter int ADDR_W     = BANK_IDX_W + WIN_LG,
    parameter int NUM_PINS   = NUM_BANKS * PIN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq_out
);
    logic [BANK_IDX_W-1:0] bank_idx;
    logic [WORD_IDX_W-1:0] word_idx;
    logic [NUM_BANKS-1:0]  bank_sel;
    logic [NUM_BANKS-1:0]  bank_irq;
    logic [PIN_W-1:0]      bank_rd [NUM_BANKS];
    logic [PIN_W-1:0]      rd_or;
    logic                  unused_bits;

    assign bank_idx    = bus_addr[ADDR_W-1:WIN_LG];
    assign word_idx    = bus_addr[WIN_LG-1:2];
    assign unused_bits = ^{bus_wdata[31:PIN_W], bus_addr[1:0]};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [PIN_W-1:0] masked_b;

        assign bank_sel[b] = (bank_idx == BANK_IDX_W'(b));

        gpiob_bank #(.W(PIN_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (bank_sel[b]),
            .we       (bus_we),
            .word_idx (word_idx),
            .wdata    (bus_wdata[PIN_W-1:0]),
            .pin_in   (pin_in[b*PIN_W +: PIN_W]),
            .rdata    (bank_rd[b]),
            .pin_out  (pin_out[b*PIN_W +: PIN_W]),
            .pin_oe   (pin_oe[b*PIN_W +: PIN_W]),
            .masked   (masked_b)
        );

        assign bank_irq[b] = |masked_b;
    end

    always_comb begin
        rd_or = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            rd_or = rd_or | (bank_rd[b] & {PIN_W{bank_sel[b]}});
        end
    end

    assign bus_rdata = {{(32-PIN_W){1'b0}}, rd_or};
    assign irq_out   = |bank_irq;

    assert_clr_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx == WORD_IDX_W'(REG_CLR)) |-> (bus_rdata == 32'h0));
endmodule

// File: tb/gpio_banked_tb_top.sv
module gpio_banked_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 16;
    localparam int NP = NB * 16;

    localparam int O_DATA = 'h00, O_DMASK = 'h04, O_DIR = 'h08, O_SENSE = 'h0C,
                   O_BOTH = 'h10, O_POL = 'h14, O_IEN = 'h18, O_RAW = 'h1C,
                   O_MSK = 'h20, O_CLR = 'h24, O_INEN = 'h28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [10:0]   bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_banked dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int bank, input int off, input logic [31:0] val);
        @(negedge clk);
        bus_addr  = 11'(bank * 128 + off);
        bus_wdata = val;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int bank, input int off, output logic [31:0] val);
        @(negedge clk);
        bus_addr = 11'(bank * 128 + off);
        #1;
        val = bus_rdata;
    endtask

    task automatic set_pin(input int idx, input logic v);
        @(negedge clk);
        pin_in[idx] = v;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, O_DIR, v);    chk("R2 dir reset", v, 0);
        rd(7, O_DMASK, v);  chk("R2 mask reset", v, 0);
        rd(15, O_INEN, v);  chk("R2 inen reset", v, 0);
        rd(0, O_RAW, v);    chk("R2 raw reset", v, 0);
        chk("R2 irq reset", {31'b0, irq_out}, 0);
        chk("R2 oe reset", {31'b0, |pin_oe}, 0);
        chk("R2 out reset", {31'b0, |pin_out}, 0);
    endtask

    task automatic t_data_mask();
        logic [31:0] v;
        wr(2, O_DIR, 32'hFFFF);
        wr(2, O_DMASK, 32'h00FF);
        wr(2, O_DATA, 32'hABCD);
        chk("R4 masked write pin_out", {16'h0, pin_out[47:32]}, 32'h00CD);
        chk("R3 oe follows dir", {16'h0, pin_oe[47:32]}, 32'hFFFF);
        rd(2, O_DATA, v);   chk("R4 read through mask", v, 32'h00CD);
        wr(2, O_DMASK, 32'hFF00);
        rd(2, O_DATA, v);   chk("R4 masked bits read 0", v, 32'h0000);
        wr(2, O_DATA, 32'h1234);
        chk("R4 second masked write", {16'h0, pin_out[47:32]}, 32'h12CD);
        rd(2, O_DATA, v);   chk("R4 read upper byte", v, 32'h1200);
        wr(3, O_DIR, 32'hFFFF_FFFF);
        rd(3, O_DIR, v);    chk("R1 upper half reads 0", v, 32'h0000FFFF);
        chk("R1 bank 3 oe slice", {16'h0, pin_oe[63:48]}, 32'hFFFF);
        wr(3, O_DIR, 0);
        chk("R3 oe cleared", {16'h0, pin_oe[63:48]}, 32'h0);
    endtask

    task automatic t_input_read();
        logic [31:0] v;
        wr(1, O_DMASK, 32'hFFFF);
        wr(1, O_DIR, 32'h00FF);
        wr(1, O_DATA, 32'h0012);
        @(negedge clk);
        pin_in[31:16] = 16'h5AFF;
        settle();
        rd(1, O_DATA, v);   chk("R5 input gated by inen", v, 32'h0012);
        wr(1, O_INEN, 32'hFFFF);
        rd(1, O_DATA, v);   chk("R5 mixed in/out read", v, 32'h5A12);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(0, O_INEN, 32'h0018);
        wr(0, O_POL, 32'h0008);
        wr(0, O_IEN, 32'h0018);
        set_pin(3, 1'b1); settle();
        rd(0, O_RAW, v);    chk("R6 rising latched", v, 32'h0008);
        chk("R11 irq on rise", {31'b0, irq_out}, 1);
        set_pin(3, 1'b0); settle();
        rd(0, O_RAW, v);    chk("R6 stays latched", v, 32'h0008);
        set_pin(4, 1'b1); settle();
        rd(0, O_RAW, v);    chk("R6 falling-mode ignores rise", v, 32'h0008);
        set_pin(4, 1'b0); settle();
        rd(0, O_RAW, v);    chk("R6 falling latched", v, 32'h0018);
        rd(0, O_MSK, v);    chk("R11 gated status", v, 32'h0018);
        wr(0, O_CLR, 32'h0008);
        rd(0, O_RAW, v);    chk("R9 partial clear", v, 32'h0010);
        wr(0, O_CLR, 32'h0010);
        rd(0, O_RAW, v);    chk("R9 full clear", v, 32'h0000);
        chk("R11 irq drops", {31'b0, irq_out}, 0);
        wr(0, O_RAW, 32'hFFFF);
        rd(0, O_RAW, v);    chk("R9 raw write ignored", v, 32'h0000);
        wr(0, O_MSK, 32'hFFFF);
        rd(0, O_MSK, v);    chk("R9 gated write ignored", v, 32'h0000);
        rd(0, O_CLR, v);    chk("R9 clear reads 0", v, 32'h0000);
        wr(0, O_IEN, 0);
    endtask

    task automatic t_both();
        logic [31:0] v;
        wr(0, O_INEN, 32'h0020);
        wr(0, O_BOTH, 32'h0020);
        wr(0, O_POL, 32'h0000);
        set_pin(5, 1'b1); settle();
        rd(0, O_RAW, v);    chk("R7 both-edge rise", v, 32'h0020);
        wr(0, O_CLR, 32'h0020);
        set_pin(5, 1'b0); settle();
        rd(0, O_RAW, v);    chk("R7 both-edge fall", v, 32'h0020);
        wr(0, O_CLR, 32'h0020);
    endtask

    task automatic t_level();
        logic [31:0] v;
        set_pin(254, 1'b1);
        wr(15, O_SENSE, 32'hC000);
        wr(15, O_POL, 32'h8000);
        wr(15, O_INEN, 32'hC000);
        settle();
        rd(15, O_RAW, v);   chk("R8 inactive levels", v, 32'h0000);
        set_pin(255, 1'b1); settle();
        rd(15, O_RAW, v);   chk("R8 active high", v, 32'h8000);
        wr(15, O_IEN, 32'h8000);
        chk("R11 irq from last bank", {31'b0, irq_out}, 1);
        set_pin(255, 1'b0); settle();
        rd(15, O_RAW, v);   chk("R8 not latched", v, 32'h0000);
        chk("R11 irq follows level", {31'b0, irq_out}, 0);
        set_pin(254, 1'b0); settle();
        rd(15, O_RAW, v);   chk("R8 active low", v, 32'h4000);
        rd(15, O_MSK, v);   chk("R11 enable gates", v, 32'h0000);
        chk("R11 irq stays low", {31'b0, irq_out}, 0);
        set_pin(254, 1'b1);
        wr(15, O_IEN, 0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        wr(4, O_INEN, 32'h0040);
        wr(4, O_BOTH, 32'h0040);
        set_pin(70, 1'b1); settle();
        rd(4, O_RAW, v);    chk("R7 race setup", v, 32'h0040);
        @(negedge clk);
        pin_in[70] = 1'b0;
        @(negedge clk);
        wr(4, O_CLR, 32'h0040);
        rd(4, O_RAW, v);    chk("R10 edge wins over clear", v, 32'h0040);
        wr(4, O_CLR, 32'h0040);
        rd(4, O_RAW, v);    chk("R9 clear without edge", v, 32'h0000);
    endtask

    task automatic t_inen_block();
        logic [31:0] v;
        wr(5, O_POL, 32'h0001);
        wr(5, O_IEN, 32'h0001);
        set_pin(80, 1'b1); settle();
        rd(5, O_RAW, v);    chk("R12 disabled input no edge", v, 32'h0000);
        chk("R12 no irq", {31'b0, irq_out}, 0);
        wr(5, O_INEN, 32'h0001); settle();
        rd(5, O_RAW, v);    chk("R12 enabling is not an edge", v, 32'h0000);
        set_pin(80, 1'b0); settle();
        set_pin(80, 1'b1); settle();
        rd(5, O_RAW, v);    chk("R12 enabled edge seen", v, 32'h0001);
        wr(5, O_CLR, 32'h0001);
        wr(5, O_IEN, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_data_mask();
        t_input_read();
        t_edge();
        t_both();
        t_level();
        t_race();
        t_inen_block();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule